// File: doc/BRIEF.md
# Shared Byte Buffer Controller with Stepping Slot Address

This block arbitrates one byte-wide buffer between a host processor and a group of expansion slots. Only one side owns the buffer at a time, and a host-written ownership bit selects which side that is. While the host owns the buffer, it reads and writes bytes at addresses taken from the low bits of its own address bus. A host access counts only when the upper host address bits equal a base value set by switches.

While the slots own the buffer, their address comes from an internal counter. The host preloads the counter through two byte-wide register writes and sets its direction through a control register. The slots read with an active-low read strobe and write with an active-low write strobe. They move the counter with an active-low step strobe. The counter stops at the last address in its current direction and does not wrap. A full flag reports that it has reached that address.

The buffer holds 2^AW bytes, and AW = 13 gives the full 8 KB size. The three slot strobes cross into the clock domain through SYNC flip-flops each. Each slot action therefore takes effect a few cycles after the strobe edge. Software decides which slot uses the buffer. The block does not arbitrate between slots.

Top module: `shbuf_ctrl`

## Requirements
- R1: After reset the host owns the buffer, the direction is up, the counter is 0, `s_full` is 0 and neither `h_rvalid` nor `s_doe` is set.
- R2: When the host owns the buffer and `h_addr[HAW-1:AW]` equals `h_base_sw`, `h_mem_wr` writes `h_wdata` to byte `h_addr[AW-1:0]`. `h_mem_rd` returns that byte on `h_rdata` with `h_rvalid` high one cycle later.
- R3: A host access whose upper address bits differ from `h_base_sw` writes nothing and gives no `h_rvalid`.
- R4: `h_reg_wr` with `h_reg_sel` = 0 loads `h_reg_data` into counter bits [7:0]. With `h_reg_sel` = 1 it loads `h_reg_data` into counter bits [AW-1:8]. With `h_reg_sel` = 2 it writes the control register: bit 0 set hands the buffer to the slots, and bit 1 set selects counting up. Bit 0 is reflected on `slot_owner`.
- R5: While the slots own the buffer and `s_rd_n` is low, `s_doe` is high and `s_rdata` carries the byte at the counter address.
- R6: While the slots own the buffer, the rising edge of `s_wr_n` writes `s_wdata` at the counter address.
- R7: While the slots own the buffer, each rising edge of `s_step_n` moves the counter by exactly one, up or down according to the direction bit.
- R8: A step at address 2^AW-1 when counting up, or at address 0 when counting down, leaves the counter unchanged.
- R9: `s_full` is high exactly when the counter sits at the terminal address of the current direction (2^AW-1 up, 0 down).
- R10: While the host owns the buffer, slot read, write and step strobes change neither the buffer nor the counter, and `s_doe` stays low.
- R11: While the slots own the buffer, host reads give no `h_rvalid` and host writes leave the buffer unchanged.
- R12: `h_rvalid` and `s_doe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | HAW | Host address |
| h_base_sw | input | HAW-AW | Switch-set base compared with the upper host address bits |
| h_mem_rd | input | 1 | Host buffer read request |
| h_mem_wr | input | 1 | Host buffer write request |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, zero unless `h_rvalid` |
| h_rvalid | output | 1 | Host read data valid; host data path enabled |
| h_reg_wr | input | 1 | Host register write strobe |
| h_reg_sel | input | 2 | Register select: 0 counter low, 1 counter high, 2 control |
| h_reg_data | input | 8 | Register write data |
| s_rd_n | input | 1 | Slot read strobe, active low |
| s_wr_n | input | 1 | Slot write strobe, active low; write on rising edge |
| s_step_n | input | 1 | Slot counter step strobe, active low; step on rising edge |
| s_wdata | input | DW | Slot write data, held stable around the write strobe's rising edge |
| s_rdata | output | DW | Slot read data, zero unless `s_doe` |
| s_doe | output | 1 | Slot data path enabled |
| s_full | output | 1 | Counter at terminal address of the current direction |
| slot_owner | output | 1 | 1 when the slots own the buffer |

## Verification
The bench fills the whole buffer from the host and sweeps it from the slot side, reading upward and writing downward. This finds a counter that skips or repeats an address and a direction bit with the wrong sense. It also shows whether the full flag comes on anywhere other than the last address. Extra steps at both terminal addresses expose a counter that wraps to the far end. Such a counter would show up as a wrong byte and a dropped full flag. Strobes sent to the side that does not own the buffer, and host accesses with a wrong base, would corrupt bytes if they leaked through. The host readback afterwards, and slot reads of the same addresses, catch that corruption. A high-byte load shows whether the upper counter bits are taken from the correct register.

// File: rtl/shbuf_pkg.sv
package shbuf_pkg;
  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CTRL   = 2'd2
  } shbuf_reg_e;

  localparam int CTRL_OWNER_BIT = 0;
  localparam int CTRL_UP_BIT    = 1;
endpackage

// File: rtl/shbuf_strobe_sync.sv
module shbuf_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] active,
  output logic [N-1:0] release_evt
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_n[g]};
        prev  <= chain[LAST];
      end
    end
    assign active[g]      = ~chain[LAST];
    assign release_evt[g] = chain[LAST] & ~prev;
  end
endmodule

// File: rtl/shbuf_addr_cnt.sv
module shbuf_addr_cnt #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    ld_data,
  input  logic          up,
  input  logic          step,
  output logic [AW-1:0] cnt,
  output logic          full
);
  localparam logic [AW-1:0] CMAX = '1;

  logic [AW-1:0] nxt;

  always_comb begin
    nxt = cnt;
    if (ld_lo || ld_hi) begin
      for (int i = 0; i < AW; i++) begin
        if (ld_lo && i < 8)  nxt[i] = ld_data[i % 8];
        if (ld_hi && i >= 8) nxt[i] = ld_data[i % 8];
      end
    end else if (step) begin
      if (up && cnt != CMAX)      nxt = cnt + 1'b1;
      else if (!up && cnt != '0)  nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      cnt  <= nxt;
      full <= up ? (cnt == CMAX) : (cnt == '0);
    end
  end
endmodule

// File: rtl/shbuf_ram.sv
module shbuf_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/shbuf_ctrl.sv
module shbuf_ctrl
  import shbuf_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 8,
  parameter int HAW  = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HAW-1:0]    h_addr,
  input  logic [HAW-AW-1:0] h_base_sw,
  input  logic              h_mem_rd,
  input  logic              h_mem_wr,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              h_rvalid,
  input  logic              h_reg_wr,
  input  logic [1:0]        h_reg_sel,
  input  logic [7:0]        h_reg_data,
  input  logic              s_rd_n,
  input  logic              s_wr_n,
  input  logic              s_step_n,
  input  logic [DW-1:0]     s_wdata,
  output logic [DW-1:0]     s_rdata,
  output logic              s_doe,
  output logic              s_full,
  output logic              slot_owner
);
  localparam int SI_RD = 0;
  localparam int SI_WR = 1;
  localparam int SI_ST = 2;

  logic          cnt_up;
  logic [AW-1:0] cnt;
  logic [2:0]    s_act, s_rel;
  logic          host_hit, host_rd_ok, host_wr_ok, slot_wr_ok;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          h_rvalid_q, s_doe_q;
  logic          ld_lo, ld_hi, ld_ctrl;

  assign ld_lo   = h_reg_wr && (h_reg_sel == REG_CNT_LO);
  assign ld_hi   = h_reg_wr && (h_reg_sel == REG_CNT_HI);
  assign ld_ctrl = h_reg_wr && (h_reg_sel == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_owner <= 1'b0;
      cnt_up     <= 1'b1;
    end else if (ld_ctrl) begin
      slot_owner <= h_reg_data[CTRL_OWNER_BIT];
      cnt_up     <= h_reg_data[CTRL_UP_BIT];
    end
  end

  shbuf_strobe_sync #(.N(3), .STAGES(SYNC)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .raw_n       ({s_step_n, s_wr_n, s_rd_n}),
    .active      (s_act),
    .release_evt (s_rel)
  );

  shbuf_addr_cnt #(.AW(AW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ld_data (h_reg_data),
    .up      (cnt_up),
    .step    (slot_owner && s_rel[SI_ST]),
    .cnt     (cnt),
    .full    (s_full)
  );

  assign host_hit   = (h_addr[HAW-1:AW] == h_base_sw);
  assign host_rd_ok = !slot_owner && host_hit && h_mem_rd;
  assign host_wr_ok = !slot_owner && host_hit && h_mem_wr;
  assign slot_wr_ok = slot_owner && s_rel[SI_WR];

  assign ram_addr  = slot_owner ? cnt : h_addr[AW-1:0];
  assign ram_wdata = slot_owner ? s_wdata : h_wdata;

  shbuf_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (host_wr_ok || slot_wr_ok),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rvalid_q <= 1'b0;
      s_doe_q    <= 1'b0;
    end else begin
      h_rvalid_q <= host_rd_ok;
      s_doe_q    <= slot_owner && s_act[SI_RD];
    end
  end

  assign h_rvalid = h_rvalid_q;
  assign s_doe    = s_doe_q;
  assign h_rdata  = h_rvalid_q ? ram_rdata : '0;
  assign s_rdata  = s_doe_q ? ram_rdata : '0;
endmodule

// File: rtl/shbuf_ctrl_chk.sv
module shbuf_ctrl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          owner,
  input logic          up,
  input logic [AW-1:0] cnt,
  input logic          reg_wr,
  input logic          h_rvalid,
  input logic          s_doe
);
  localparam logic [AW-1:0] CMAX = '1;

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    !(h_rvalid && s_doe)); // R12

  AST_HOST_SHUT: assert property (@(posedge clk) disable iff (rst)
    owner |=> !h_rvalid); // R11

  AST_SLOT_SHUT: assert property (@(posedge clk) disable iff (rst)
    (!owner && !reg_wr) |=> $stable(cnt)); // R10

  AST_HOLD_TOP: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && up && cnt == CMAX) |=> cnt == CMAX); // R8

  AST_HOLD_BOT: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !up && cnt == '0) |=> cnt == '0); // R8

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 ||
                 cnt == $past(cnt) - 1'b1)); // R7
endmodule

bind shbuf_ctrl shbuf_ctrl_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .owner    (slot_owner),
  .up       (cnt_up),
  .cnt      (cnt),
  .reg_wr   (h_reg_wr),
  .h_rvalid (h_rvalid),
  .s_doe    (s_doe)
);

// File: tb/shbuf_ctrl_test.sv
module shbuf_ctrl_test;
  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int HAW = 12;
  localparam int TOP = (1 << AW) - 1;
  localparam logic [1:0] BASE = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HAW-1:0] h_addr = '0;
  logic [1:0]     h_base_sw = BASE;
  logic h_mem_rd = 0, h_mem_wr = 0, h_reg_wr = 0;
  logic [DW-1:0]  h_wdata = '0, s_wdata = '0;
  logic [1:0]     h_reg_sel = '0;
  logic [7:0]     h_reg_data = '0;
  logic s_rd_n = 1, s_wr_n = 1, s_step_n = 1;
  logic [DW-1:0]  h_rdata, s_rdata;
  logic h_rvalid, s_doe, s_full, slot_owner;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  shbuf_ctrl #(.AW(AW), .DW(DW), .HAW(HAW), .SYNC(2)) uut (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_base_sw(h_base_sw),
    .h_mem_rd(h_mem_rd), .h_mem_wr(h_mem_wr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_reg_wr(h_reg_wr),
    .h_reg_sel(h_reg_sel), .h_reg_data(h_reg_data), .s_rd_n(s_rd_n),
    .s_wr_n(s_wr_n), .s_step_n(s_step_n), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_doe(s_doe), .s_full(s_full), .slot_owner(slot_owner)
  );

  function automatic logic [7:0] pat_f(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] pat_g(int a);
    return 8'((a ^ (a >> 2) ^ 8'h5A) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [7:0] d);
    h_reg_wr = 1; h_reg_sel = sel; h_reg_data = d;
    cyc(1);
    h_reg_wr = 0;
  endtask

  task automatic host_wr(logic [1:0] base, int a, logic [7:0] d);
    h_addr = {base, AW'(a)}; h_wdata = d; h_mem_wr = 1;
    cyc(1);
    h_mem_wr = 0;
  endtask

  task automatic host_rd(logic [1:0] base, int a, output logic v, output logic [7:0] d);
    h_addr = {base, AW'(a)}; h_mem_rd = 1;
    cyc(1);
    v = h_rvalid; d = h_rdata;
    h_mem_rd = 0;
  endtask

  task automatic slot_rd(output logic oe, output logic [7:0] d);
    s_rd_n = 0;
    cyc(5);
    oe = s_doe; d = s_rdata;
    s_rd_n = 1;
    cyc(4);
  endtask

  task automatic slot_wr(logic [7:0] d);
    s_wdata = d; s_wr_n = 0;
    cyc(4);
    s_wr_n = 1;
    cyc(5);
  endtask

  task automatic slot_step();
    s_step_n = 0;
    cyc(4);
    s_step_n = 1;
    cyc(5);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic v, oe;
    logic [7:0] d;
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 owner", slot_owner, 0);
    chk("R1 full", s_full, 0);
    chk("R1 rvalid", h_rvalid, 0);
    chk("R1 doe", s_doe, 0);

    for (int a = 0; a <= TOP; a++) host_wr(BASE, a, pat_f(a));
    for (int a = 0; a <= TOP; a++) begin
      host_rd(BASE, a, v, d);
      chk("R2 rvalid", v, 1);
      chk("R2 data", d, pat_f(a));
    end

    host_wr(2'b01, 5, 8'hEE);
    host_rd(BASE, 5, v, d);
    chk("R3 write ignored", d, pat_f(5));
    host_rd(2'b01, 5, v, d);
    chk("R3 no rvalid", v, 0);

    // R1 reset counter is 0 and direction up; hand buffer to slots
    reg_wr(2'd2, 8'h03);
    chk("R4 owner bit", slot_owner, 1);
    for (int a = 0; a <= TOP; a++) begin
      slot_rd(oe, d);
      chk("R5 doe", oe, 1);
      chk("R5 R7 data up", d, pat_f(a));
      chk("R9 full up", s_full, (a == TOP) ? 1 : 0);
      slot_step();
    end
    slot_rd(oe, d);
    chk("R8 no wrap top", d, pat_f(TOP));
    chk("R8 full held", s_full, 1);

    reg_wr(2'd2, 8'h01);
    cyc(2);
    chk("R9 full drops on direction", s_full, 0);
    for (int a = TOP; a >= 0; a--) begin
      slot_wr(pat_g(a));
      slot_step();
    end
    chk("R9 full down", s_full, 1);
    slot_rd(oe, d);
    chk("R8 no wrap bottom", d, pat_g(0));

    host_rd(BASE, 0, v, d);
    chk("R11 no host read", v, 0);
    host_wr(BASE, 0, 8'h11);
    s_rd_n = 0; h_mem_rd = 1; h_addr = {BASE, AW'(0)};
    cyc(5);
    chk("R12 doe", s_doe, 1);
    chk("R12 rvalid", h_rvalid, 0);
    chk("R11 write ignored", s_rdata, pat_g(0));
    s_rd_n = 1; h_mem_rd = 0;
    cyc(4);

    reg_wr(2'd2, 8'h00);
    s_rd_n = 0;
    cyc(5);
    chk("R10 doe off", s_doe, 0);
    s_rd_n = 1;
    cyc(4);
    slot_wr(8'h99);
    slot_step();
    for (int a = 0; a <= TOP; a++) begin
      host_rd(BASE, a, v, d);
      chk("R6 R10 content", d, pat_g(a));
    end
    reg_wr(2'd2, 8'h01);
    slot_rd(oe, d);
    chk("R10 step ignored", d, pat_g(0));
    chk("R10 full", s_full, 1);

    reg_wr(2'd0, 8'h34);
    reg_wr(2'd1, 8'h02);
    reg_wr(2'd2, 8'h03);
    slot_rd(oe, d);
    chk("R4 counter load", d, pat_g(12'h234));
    chk("R9 mid not full", s_full, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule